// File: doc/BRIEF.md
# Trigger Timestamp Event Capture

This block runs a 32-bit local time counter from the 50 MHz system clock. It watches five trigger lines, each with its own enable. When any enabled trigger rises, the block writes one 64-bit record into an on-chip event queue. The record holds:

- the time count;
- a 20-bit event number, made of a 16-bit value from an event-number bus and a 4-bit wrap count kept by the block;
- four busy flags and three veto/auxiliary flags;
- the mask of the triggers that fired.

Trigger 4 can come either from its own pin or from the strobe that travels on the event-number bus. A host drains the queue through a simple pop port. A "new data" level and a "full" level show how full the queue is. A sticky overflow flag records that a capture was dropped. One counter bit, chosen from an eight-bit window, is brought out as a slow rollover output. Separate clear pulses reset the time counter, the queue and the wrap count.

Top module: `evs_stamp_top`

## Requirements
- R1: `time_clr` sampled high on an edge sets the counter to 0; otherwise the counter adds 1 on every edge. A trigger first sampled high on edge k is written on edge k+2. Its time field is the counter value held after edge k+1.
- R2: Record bit fields: [31:0] time, [47:32] event-number bus value, [51:48] wrap count, [55:52] `busy_in`, [58:56] `flag_in`, [63:59] trigger mask, with bit 59 for trigger 0. The bus and flag inputs are those sampled on edge k+1.
- R3: The wrap count adds 1 only when the bus value changes from 0xFFFF to 0x0000 on consecutive edges. Any other change, such as 0x8000 to 0x0000, leaves it unchanged.
- R4: A `wrap_clr` pulse sets the wrap count to 0.
- R5: The mask is the rising-edge set ANDed with `trig_en`. Triggers that rise on the same edge share one record. A rise on a disabled line only writes no record.
- R6: With `trig4_bus`=1, trigger 4 is `gtrig` and `trig_in[4]` is ignored. With `trig4_bus`=0, trigger 4 is `trig_in[4]` and `gtrig` is ignored.
- R7: A trigger held high for many cycles produces exactly one record.
- R8: Records are popped in write order. `rd_data` is valid after the edge that samples `rd_en` while `new_data`=1. `new_data` is 1 while the queue holds a record, and `fifo_full` is 1 while it holds 2^FIFO_AW records.
- R9: A capture that arrives while `fifo_full`=1 is dropped and sets `overflow`. `overflow` stays set until `fifo_clr`, which also empties the queue.
- R10: `roll_out` equals counter bit ROLL_BASE+`roll_sel` of the counter value held one edge earlier.
- R11: While `rst` is high and after reset: the counter is 0, and `new_data`, `fifo_full`, `overflow` and `roll_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz clock |
| rst | input | 1 | synchronous active-high reset |
| time_clr | input | 1 | clear time counter |
| fifo_clr | input | 1 | empty queue, clear overflow |
| wrap_clr | input | 1 | clear event-number wrap count |
| trig_in | input | 5 | trigger lines 0..4 |
| trig_en | input | 5 | per-trigger enable |
| trig4_bus | input | 1 | trigger 4 taken from bus strobe |
| gtrig | input | 1 | bus strobe |
| evn_in | input | 16 | event-number bus value |
| busy_in | input | 4 | busy flags |
| flag_in | input | 3 | veto/auxiliary flags |
| roll_sel | input | 3 | rollover bit select |
| rd_en | input | 1 | pop one record |
| rd_data | output | 64 | popped record |
| new_data | output | 1 | queue not empty |
| fifo_full | output | 1 | queue full |
| overflow | output | 1 | sticky dropped-capture flag |
| roll_out | output | 1 | selected counter bit |

## Verification
The bench builds the block with FIFO_AW=3 and ROLL_BASE=2. The eight-deep queue fills after a handful of captures, so the full, drop and overflow path and the read order across a whole queue are checked directly. A low rollover window lets `roll_out` toggle within tens of cycles, so both select values can be compared against the counter's expected bit pattern.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int TIME_W = 32;
  localparam int EVN_W  = 16;
  localparam int WRAP_W = 4;
  localparam int NBUSY  = 4;
  localparam int NFLAG  = 3;
  localparam int NTRIG  = 5;
  localparam int REC_W  = TIME_W + EVN_W + WRAP_W + NBUSY + NFLAG + NTRIG;

  // MSB first: trigger mask on top, time stamp at the bottom
  typedef struct packed {
    logic [NTRIG-1:0]  trig;
    logic [NFLAG-1:0]  flags;
    logic [NBUSY-1:0]  busy;
    logic [WRAP_W-1:0] wrap;
    logic [EVN_W-1:0]  evn;
    logic [TIME_W-1:0] stamp;
  } rec_t;
endpackage

// File: rtl/evs_trig_edge.sv
module evs_trig_edge #(
  parameter int N      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-1:0], din[i]};
    end
    assign rise[i] = sh[STAGES-1] & ~sh[STAGES];
  end
endmodule

// File: rtl/evs_evnum_ext.sv
module evs_evnum_ext
  import evs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap_clr,
  input  logic [EVN_W-1:0]  evn_in,
  output logic [EVN_W-1:0]  evn_q,
  output logic [WRAP_W-1:0] wrap_cnt
);
  logic wrapped;
  assign wrapped = (evn_q == '1) && (evn_in == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      evn_q    <= '0;
      wrap_cnt <= '0;
    end else begin
      evn_q <= evn_in;
      if (wrap_clr)     wrap_cnt <= '0;
      else if (wrapped) wrap_cnt <= wrap_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/evs_fifo.sv
module evs_fifo #(
  parameter int AW = 12,
  parameter int W  = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         not_empty,
  output logic         full,
  output logic         ovf
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt, cnt_n;
  logic          do_wr, do_rd;

  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && not_empty;

  always_comb begin
    cnt_n = cnt;
    if (do_wr && !do_rd)      cnt_n = cnt + 1'b1;
    else if (do_rd && !do_wr) cnt_n = cnt - 1'b1;
  end

  // plain write and registered read ports, suitable for block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      not_empty <= 1'b0;
      full      <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      cnt       <= cnt_n;
      not_empty <= (cnt_n != '0);
      full      <= (cnt_n == DEPTH[AW:0]);
      if (wr_en && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/evs_stamp_top.sv
module evs_stamp_top
  import evs_pkg::*;
#(
  parameter int FIFO_AW     = 12,
  parameter int ROLL_BASE   = 24,
  parameter int ROLL_SEL_W  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  time_clr,
  input  logic                  fifo_clr,
  input  logic                  wrap_clr,
  input  logic [NTRIG-1:0]      trig_in,
  input  logic [NTRIG-1:0]      trig_en,
  input  logic                  trig4_bus,
  input  logic                  gtrig,
  input  logic [EVN_W-1:0]      evn_in,
  input  logic [NBUSY-1:0]      busy_in,
  input  logic [NFLAG-1:0]      flag_in,
  input  logic [ROLL_SEL_W-1:0] roll_sel,
  input  logic                  rd_en,
  output logic [REC_W-1:0]      rd_data,
  output logic                  new_data,
  output logic                  fifo_full,
  output logic                  overflow,
  output logic                  roll_out
);
  localparam int ROLL_SPAN = 1 << ROLL_SEL_W;

  logic [TIME_W-1:0]    stamp_q;
  logic [ROLL_SPAN-1:0] roll_win;
  logic [NTRIG-1:0]     trig_src, trig_rise, cap_mask;
  logic                 cap_req;
  logic [EVN_W-1:0]     evn_q;
  logic [WRAP_W-1:0]    wrap_cnt;
  logic [NBUSY-1:0]     busy_q;
  logic [NFLAG-1:0]     flag_q;
  rec_t                 rec;

  // free-running time counter and rollover tap
  always_ff @(posedge clk) begin
    if (rst || time_clr) stamp_q <= '0;
    else                 stamp_q <= stamp_q + 1'b1;
  end

  assign roll_win = stamp_q[ROLL_BASE +: ROLL_SPAN];

  always_ff @(posedge clk) begin
    if (rst) roll_out <= 1'b0;
    else     roll_out <= roll_win[roll_sel];
  end

  // trigger source: last line may come from the bus strobe
  assign trig_src = {trig4_bus ? gtrig : trig_in[NTRIG-1], trig_in[NTRIG-2:0]};

  evs_trig_edge #(.N(NTRIG), .STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (trig_src),
    .rise (trig_rise)
  );

  assign cap_mask = trig_rise & trig_en;
  assign cap_req  = |cap_mask;

  evs_evnum_ext u_evn (
    .clk      (clk),
    .rst      (rst),
    .wrap_clr (wrap_clr),
    .evn_in   (evn_in),
    .evn_q    (evn_q),
    .wrap_cnt (wrap_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      flag_q <= '0;
    end else begin
      busy_q <= busy_in;
      flag_q <= flag_in;
    end
  end

  always_comb begin
    rec.trig  = cap_mask;
    rec.flags = flag_q;
    rec.busy  = busy_q;
    rec.wrap  = wrap_cnt;
    rec.evn   = evn_q;
    rec.stamp = stamp_q;
  end

  evs_fifo #(.AW(FIFO_AW), .W(REC_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .clr       (fifo_clr),
    .wr_en     (cap_req),
    .wr_data   (rec),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .not_empty (new_data),
    .full      (fifo_full),
    .ovf       (overflow)
  );
endmodule

// File: rtl/evs_checker.sv
module evs_checker
  import evs_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              time_clr,
  input logic              fifo_clr,
  input logic              wrap_clr,
  input logic [TIME_W-1:0] stamp,
  input logic [WRAP_W-1:0] wrap,
  input logic              cap_req,
  input logic              new_data,
  input logic              fifo_full,
  input logic              overflow
);
  logic [1:0] up;
  always_ff @(posedge clk) begin
    if (rst) up <= '0;
    else     up <= {up[0], 1'b1};
  end

  a_r1_stamp_step: assert property (@(posedge clk) disable iff (rst)
    up[1] && !$past(time_clr) |-> stamp == $past(stamp) + 1'b1);

  a_r1_stamp_clear: assert property (@(posedge clk) disable iff (rst)
    time_clr |=> stamp == '0);

  a_r3_wrap_step: assert property (@(posedge clk) disable iff (rst)
    up[1] && !$past(wrap_clr) && (wrap != $past(wrap)) |-> wrap == $past(wrap) + 1'b1);

  a_r4_wrap_clear: assert property (@(posedge clk) disable iff (rst)
    wrap_clr |=> wrap == '0);

  a_r8_full_has_data: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> new_data);

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow && !fifo_clr |=> overflow);

  a_r9_ovf_cause: assert property (@(posedge clk) disable iff (rst)
    up[1] && $rose(overflow) |-> $past(fifo_full && cap_req));

  a_r11_reset_quiet: assert property (@(posedge clk)
    rst |=> !new_data && !fifo_full && !overflow && stamp == '0);
endmodule

bind evs_stamp_top evs_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .time_clr  (time_clr),
  .fifo_clr  (fifo_clr),
  .wrap_clr  (wrap_clr),
  .stamp     (stamp_q),
  .wrap      (wrap_cnt),
  .cap_req   (cap_req),
  .new_data  (new_data),
  .fifo_full (fifo_full),
  .overflow  (overflow)
);

// File: tb/evs_stamp_top_test.sv
module evs_stamp_top_test;
  localparam int AW   = 3;
  localparam int RB   = 2;
  localparam int NV   = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        time_clr = 0, fifo_clr = 0, wrap_clr = 0;
  logic [4:0]  trig_in = 0, trig_en = 5'h1F;
  logic        trig4_bus = 0, gtrig = 0;
  logic [15:0] evn_in = 0;
  logic [3:0]  busy_in = 0;
  logic [2:0]  flag_in = 0;
  logic [2:0]  roll_sel = 0;
  logic        rd_en = 0;
  logic [63:0] rd_data;
  logic        new_data, fifo_full, overflow, roll_out;

  int nvec = 0;
  int nbad = 0;

  always #2 clk = ~clk;

  evs_stamp_top #(.FIFO_AW(AW), .ROLL_BASE(RB)) uut (
    .clk(clk), .rst(rst), .time_clr(time_clr), .fifo_clr(fifo_clr),
    .wrap_clr(wrap_clr), .trig_in(trig_in), .trig_en(trig_en),
    .trig4_bus(trig4_bus), .gtrig(gtrig), .evn_in(evn_in),
    .busy_in(busy_in), .flag_in(flag_in), .roll_sel(roll_sel),
    .rd_en(rd_en), .rd_data(rd_data), .new_data(new_data),
    .fifo_full(fifo_full), .overflow(overflow), .roll_out(roll_out)
  );

  // [39:35] trig, [34] gtrig, [33] trig4_bus, [32:28] enable,
  // [27:12] event number, [11:8] busy, [7:5] flags, [4:0] expected mask
  localparam logic [39:0] VEC [NV] = '{
    {5'b00001, 1'b0, 1'b0, 5'h1F, 16'h0010, 4'h1, 3'h1, 5'b00001},
    {5'b01010, 1'b0, 1'b0, 5'h1F, 16'h1234, 4'hA, 3'h5, 5'b01010},
    {5'b01111, 1'b1, 1'b1, 5'h1F, 16'hBEEF, 4'hF, 3'h7, 5'b11111},
    {5'b10000, 1'b0, 1'b1, 5'h1F, 16'h0001, 4'h3, 3'h2, 5'b00000},
    {5'b00111, 1'b0, 1'b0, 5'h1A, 16'h4242, 4'h6, 3'h4, 5'b00010},
    {5'b10000, 1'b1, 1'b0, 5'h1F, 16'h7777, 4'h9, 3'h3, 5'b10000},
    {5'b11111, 1'b0, 1'b0, 5'h00, 16'h5555, 4'h5, 3'h6, 5'b00000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // clear time, wait d edges, raise triggers; record time is d+2
  task automatic fire(input logic [4:0] t, input logic g, input int d);
    @(negedge clk); time_clr = 1;
    @(negedge clk); time_clr = 0;
    repeat (d) @(negedge clk);
    trig_in = t; gtrig = g;
    repeat (3) @(negedge clk);
    trig_in = 0; gtrig = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    check("R11 new_data", 64'(new_data), 64'd0);
    check("R11 full", 64'(fifo_full), 64'd0);
    check("R11 overflow", 64'(overflow), 64'd0);
    check("R11 roll_out", 64'(roll_out), 64'd0);

    // table walk: R1 R2 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      logic [63:0] exp;
      v = VEC[i];
      @(negedge clk);
      trig_en = v[32:28]; trig4_bus = v[33];
      evn_in = v[27:12]; busy_in = v[11:8]; flag_in = v[7:5];
      repeat (2) @(negedge clk);
      fire(v[39:35], v[34], i);
      exp = {v[4:0], v[7:5], v[11:8], 4'h0, v[27:12], 32'(i + 2)};
      if (v[4:0] != 0) begin
        check("R8 new_data after capture", 64'(new_data), 64'd1);
        pop();
        check("R1 R2 R5 R6 record", rd_data, exp);
        check("R8 drained", 64'(new_data), 64'd0);
      end else begin
        check("R5 R6 ignored line writes nothing", 64'(new_data), 64'd0);
      end
    end
    trig_en = 5'h1F; trig4_bus = 0;

    // R7: long pulse gives a single record
    @(negedge clk); trig_in = 5'b00100;
    repeat (12) @(negedge clk); trig_in = 0;
    repeat (4) @(negedge clk);
    check("R7 one record present", 64'(new_data), 64'd1);
    pop();
    check("R7 mask", 64'(rd_data[63:59]), 64'b00100);
    check("R7 no second record", 64'(new_data), 64'd0);

    // R3 wrap on 0xFFFF -> 0x0000
    evn_in = 16'hFFFF; repeat (2) @(negedge clk);
    evn_in = 16'h0000; repeat (2) @(negedge clk);
    fire(5'b00001, 0, 0); pop();
    check("R3 wrap increments", 64'(rd_data[51:32]), 64'h10000);
    evn_in = 16'h8000; repeat (2) @(negedge clk);
    evn_in = 16'h0000; repeat (2) @(negedge clk);
    fire(5'b00001, 0, 0); pop();
    check("R3 non-wrap change keeps count", 64'(rd_data[51:32]), 64'h10000);
    @(negedge clk); wrap_clr = 1; @(negedge clk); wrap_clr = 0;
    fire(5'b00001, 0, 0); pop();
    check("R4 wrap cleared", 64'(rd_data[51:32]), 64'h00000);

    // R8 R9 fill, drop, order, clear
    for (int k = 0; k < 8; k++) begin
      evn_in = 16'(k + 100); repeat (2) @(negedge clk);
      fire(5'b00010, 0, 0);
    end
    check("R8 full after 8", 64'(fifo_full), 64'd1);
    check("R9 no overflow yet", 64'(overflow), 64'd0);
    evn_in = 16'd999; repeat (2) @(negedge clk);
    fire(5'b00010, 0, 0);
    check("R9 overflow set", 64'(overflow), 64'd1);
    for (int k = 0; k < 8; k++) begin
      pop();
      check("R8 R9 order, dropped record absent", 64'(rd_data[47:32]), 64'(k + 100));
      if (k == 0) check("R8 full clears on pop", 64'(fifo_full), 64'd0);
    end
    check("R8 empty after drain", 64'(new_data), 64'd0);
    check("R9 overflow sticky", 64'(overflow), 64'd1);
    fire(5'b00010, 0, 0);
    @(negedge clk); fifo_clr = 1; @(negedge clk); fifo_clr = 0;
    check("R9 clear empties", 64'(new_data), 64'd0);
    check("R9 clear drops overflow", 64'(overflow), 64'd0);

    // R10 rollover tap
    for (int s = 0; s < 2; s++) begin
      @(negedge clk); roll_sel = 3'(s); time_clr = 1;
      @(negedge clk); time_clr = 0;
      for (int n = 1; n <= 20; n++) begin
        @(negedge clk);
        check("R10 roll_out", 64'(roll_out), 64'(((n - 1) >> (RB + s)) & 1));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule